// File: doc/BRIEF.md
# Three-Level Fail Diagnosis Unloader

This block sits at the end of a concurrent interconnect test. It runs once per test period. Each period it receives two words with one bit per concurrently tested block. The pass word carries the detector results: 1 means pass and 0 means fail. The type word carries the bridge-comparator outputs: 0 means a bridge defect, and 1 means fault-free or an open defect. When every pass bit is 1, the pad simply shows a driven high pass level. When any bit fails, the block spends exactly one test period per block telling the tester both where each fault is and what kind it is.

It does this in the same period for each block by using three pad levels:
- A passing block releases the pad to high impedance, which the tester reads as a mid-band level.
- A failing block drives the pad with its type bit: high for an open defect, low for a bridge defect.

The capture interface is valid/ready. A word pair is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` drops from the edge that takes a failing word until the unload finishes. A source may hold `in_valid` and its data steady while `in_ready` is low; the held word is taken on the first edge after `in_ready` returns high. A 2-bit code per block is also exposed so that a bench can read the classification directly.

Top module: `diag_unload_top`

## Requirements
- R1: A word pair is captured only on a rising edge where `in_valid` and `in_ready` are both high; `in_ready` is high whenever the block is neither armed nor unloading.
- R2: Outside an unload, `pad_oe_n` is 0 and `pad_do` equals the AND of the last captured pass word (1 after reset).
- R3: A captured pass word containing any 0 makes `busy` rise on the next rising edge, and `busy` then stays high for exactly NUM_BLK clock periods.
- R4: During the unload, period k (k = 0 first) presents block k, meaning bit k of both captured words.
- R5: In an unload period whose pass bit is 1, `pad_oe_n` is 1 (pad released).
- R6: In an unload period whose pass bit is 0, `pad_oe_n` is 0 and `pad_do` equals the type bit: 1 for an open defect, 0 for a bridge defect.
- R7: `diag_code` gives 2'b00 for a passing block, 2'b10 for an open defect and 2'b11 for a bridge defect during the unload, and 2'b00 outside it.
- R8: A captured pass word of all ones starts no unload: `busy` stays 0 and `in_ready` stays 1.
- R9: While armed or busy, `in_ready` is 0, and a word offered on `in_valid` neither alters the unload in progress nor is lost; it is taken after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture word pair offered |
| in_ready | output | 1 | Block can take a word pair this edge |
| in_pass | input | NUM_BLK | Detector results, 1 = pass |
| in_type | input | NUM_BLK | Bridge comparator outputs, 0 = bridge |
| pad_do | output | 1 | Pad data |
| pad_oe_n | output | 1 | Pad output enable, active low (1 = high impedance) |
| busy | output | 1 | Unload in progress |
| diag_code | output | 2 | Per-block classification of the block being unloaded |

## Verification
The hardest situation to reach is a second word arriving while an unload is still running. That word must be held off without disturbing the bits being shifted out, and then taken on exactly the edge after `busy` falls. The bench reaches this by holding `in_valid` high with a different failing word from the edge that takes the first word. It checks every one of the first word's ten positions, and then checks that the second word is armed and unloaded in turn. Single-fault words at block 0 and at the last block also exercise both ends of the shift order.

// File: rtl/unload_pkg.sv
package unload_pkg;
  typedef logic [1:0] diag_code_t;
  localparam diag_code_t CODE_PASS   = 2'b00;
  localparam diag_code_t CODE_OPEN   = 2'b10;
  localparam diag_code_t CODE_BRIDGE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SHIFT = 2'd2
  } unl_state_t;
endpackage

// File: rtl/piso_reg.sv
module piso_reg #(
  parameter int   WIDTH = 10,
  parameter logic FILL  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] d,
  output logic             q_lsb
);
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= {WIDTH{FILL}};
    else if (load)   sr <= d;
    else if (shift)  sr <= {FILL, sr[WIDTH-1:1]};
  end

  assign q_lsb = sr[0];

  // R1: a load presents the captured bit 0 on the next cycle
  assert_load_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_lsb == $past(d[0])));
endmodule

// File: rtl/unload_ctrl.sv
module unload_ctrl
  import unload_pkg::*;
#(
  parameter int NUM_BLK = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic fail,
  output logic busy,
  output logic in_ready,
  output logic shift_en
);
  localparam int CNT_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BLK - 1);

  unl_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (accept && fail) state <= ST_ARM;
        ST_ARM: begin
          state <= ST_SHIFT;
          cnt   <= '0;
        end
        ST_SHIFT: begin
          if (cnt == LAST) state <= ST_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state == ST_SHIFT);
  assign in_ready = (state == ST_IDLE);
  assign shift_en = busy;

  // R3: unload ends after the last block period
  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> !busy);
  // R3: busy only begins one cycle after arming
  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(state == ST_ARM));
  // R9: no capture is possible while busy
  assert_no_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R8: a passing capture leaves the block idle
  assert_pass_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fail) |=> (state == ST_IDLE));
endmodule

// File: rtl/pad_encoder.sv
module pad_encoder
  import unload_pkg::*;
(
  input  logic       busy,
  input  logic       pass_bit,
  input  logic       type_bit,
  input  logic       result,
  output logic       pad_do,
  output logic       pad_oe_n,
  output diag_code_t code
);
  always_comb begin
    if (busy) begin
      pad_oe_n = pass_bit;
      pad_do   = type_bit;
      if (pass_bit)      code = CODE_PASS;
      else if (type_bit) code = CODE_OPEN;
      else               code = CODE_BRIDGE;
    end else begin
      pad_oe_n = 1'b0;
      pad_do   = result;
      code     = CODE_PASS;
    end
  end
endmodule

// File: rtl/diag_unload_top.sv
module diag_unload_top
  import unload_pkg::*;
#(
  parameter int NUM_BLK = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NUM_BLK-1:0] in_pass,
  input  logic [NUM_BLK-1:0] in_type,
  output logic               pad_do,
  output logic               pad_oe_n,
  output logic               busy,
  output logic [1:0]         diag_code
);
  logic accept, fail, shift_en, result_q;
  logic pass_bit, type_bit;

  assign accept = in_valid && in_ready;
  assign fail   = ~&in_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= 1'b1;
    else if (accept) result_q <= ~fail;
  end

  unload_ctrl #(.NUM_BLK(NUM_BLK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fail(fail),
    .busy(busy), .in_ready(in_ready), .shift_en(shift_en)
  );

  piso_reg #(.WIDTH(NUM_BLK), .FILL(1'b1)) u_pass_sr (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift_en),
    .d(in_pass), .q_lsb(pass_bit)
  );

  piso_reg #(.WIDTH(NUM_BLK), .FILL(1'b1)) u_type_sr (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift_en),
    .d(in_type), .q_lsb(type_bit)
  );

  pad_encoder u_enc (
    .busy(busy), .pass_bit(pass_bit), .type_bit(type_bit),
    .result(result_q), .pad_do(pad_do), .pad_oe_n(pad_oe_n),
    .code(diag_code)
  );

  // R2: pad is always driven outside an unload
  assert_idle_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pad_oe_n);
  // R5: a passing position releases the pad
  assert_pass_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && diag_code == CODE_PASS) |-> pad_oe_n);
  // R6: a bridge position drives low, an open position drives high
  assert_type_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pad_oe_n) |-> (pad_do == (diag_code == CODE_OPEN)));
  // R2: a failing capture shows a driven low on the next cycle
  assert_fail_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fail) |=> (!pad_do && !pad_oe_n && !busy));
endmodule

// File: tb/sim_diag_unload_top.sv
`timescale 1ns/1ps
module sim_diag_unload_top;
  localparam int N = 10;
  localparam int NV = 6;
  localparam logic [N-1:0] VP [NV] = '{10'h3FF, 10'h3FE, 10'h1FF, 10'h000, 10'h155, 10'h3FF};
  localparam logic [N-1:0] VT [NV] = '{10'h000, 10'h3FF, 10'h000, 10'h2AA, 10'h0F0, 10'h3FF};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [N-1:0] in_pass = '1, in_type = '1;
  logic in_ready, pad_do, pad_oe_n, busy;
  logic [1:0] diag_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  diag_unload_top #(.NUM_BLK(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pass(in_pass), .in_type(in_type), .pad_do(pad_do),
    .pad_oe_n(pad_oe_n), .busy(busy), .diag_code(diag_code)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at the negedge of the armed cycle; walks the ten periods.
  task automatic unload_check(input logic [N-1:0] p, input logic [N-1:0] t);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check("R3 busy during unload", busy, 1);
      check("R9 in_ready low while busy", in_ready, 0);
      if (p[k]) begin
        check("R5 pass position released", pad_oe_n, 1);
        check("R7 code pass", diag_code, 0);
      end else begin
        check("R6 fail position driven", pad_oe_n, 0);
        check("R6 R4 type level", pad_do, t[k]);
        check("R7 code fail", diag_code, t[k] ? 2 : 3);
      end
    end
    @(negedge clk);
    check("R3 busy ends after N periods", busy, 0);
    check("R1 ready after unload", in_ready, 1);
    check("R2 driven fail level oe", pad_oe_n, 0);
    check("R2 driven fail level", pad_do, 0);
    check("R7 code idle", diag_code, 0);
  endtask

  task automatic send(input logic [N-1:0] p, input logic [N-1:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_pass = p; in_type = t;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 idle result oe", pad_oe_n, 0);
    check("R2 idle result level", pad_do, int'(&p));
    check("R3 not busy in armed cycle", busy, 0);
    if (&p) begin
      check("R8 ready after pass word", in_ready, 1);
      @(negedge clk);
      check("R8 no unload for pass word", busy, 0);
    end else begin
      check("R1 not ready when armed", in_ready, 0);
      unload_check(p, t);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R2 reset oe", pad_oe_n, 0);
    check("R2 reset level", pad_do, 1);
    check("R3 reset busy", busy, 0);
    check("R1 reset ready", in_ready, 1);
    check("R7 reset code", diag_code, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) send(VP[i], VT[i]);

    // R9: word B held on in_valid through A's unload, then taken
    @(negedge clk);
    in_valid = 1'b1; in_pass = 10'h2F7; in_type = 10'h008;
    @(posedge clk);
    @(negedge clk);
    in_pass = 10'h0FF; in_type = 10'h100;
    check("R9 A armed, not ready", in_ready, 0);
    unload_check(10'h2F7, 10'h008);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 held word taken, armed", in_ready, 0);
    check("R9 held word fail level", pad_do, 0);
    unload_check(10'h0FF, 10'h100);

    // R4: single fault at the last block only
    send(10'h1FF, 10'h1FF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule